// File: doc/BRIEF.md
# Debug breakpoint and watchpoint unit

This unit sits beside a processor pipeline and compares every instruction fetch and every data access against a small set of debug registers. It holds two instruction-breakpoint registers, two data-address registers, a watch control register, a debug status register and a fault status register. Software programs them through a simple register port. When a fetch or access matches, the unit raises a one-cycle debug event and records a method-of-entry code. A core-side software breakpoint strobe is recorded through the same path.

The second data-address register has two roles. It can be an independent watch address with its own mode, or an ignore-mask applied to the first register, which gives one watch over a power-of-two aligned range. An event caused by either watchpoint carries the same code, so the cause recorded is only that a watchpoint fired.

Register map (reg_addr): 0 = breakpoint 0, 1 = breakpoint 1, 2 = data address 0, 3 = data address 1, 4 = watch control, 5 = debug status, 6 = fault status.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset all seven registers read zero, and dbg_event, dbg_moe and dbg_global_en are 0.
- R2: A breakpoint register with bit 0 set hits when fetch_valid is high and fetch_addr[31:2] equals register bits [31:2]. fetch_addr[1:0] is ignored. The hit gives dbg_event and a method-of-entry code of 1.
- R3: A breakpoint register with bit 0 clear, including one written to zero, never hits. No fetch hits while fetch_valid is low.
- R4: The watch modes sit in watch control bits [1:0] for watchpoint 0 and bits [3:2] for watchpoint 1, with the codes 0 = off, 1 = write, 2 = any access and 3 = read. A write hit needs data_write high and a read hit needs it low. Address equality is checked over all address bits.
- R5: Debug status bit 31 is the global enable and is shown on dbg_global_en. While it is 0, no watchpoint hits. Instruction and software breakpoints are not affected by it.
- R6: When watch control bit 8 is set, address bits that are 1 in data address 1 are left out of the watchpoint 0 compare, and watchpoint 1 never hits.
- R7: A hit on either watchpoint gives the same method-of-entry code of 2.
- R8: A high sw_bkpt gives a debug event with a method-of-entry code of 3.
- R9: When causes coincide in one cycle, the code recorded is 1 (instruction breakpoint) first, then 3 (software breakpoint), then 2 (watchpoint).
- R10: dbg_event is a one-cycle pulse in the clock cycle after the matching input. The method-of-entry code, in debug status bits [4:2] and on dbg_moe, holds until the next event or a software write to debug status. An event in the same cycle as such a write wins.
- R11: Fault status bit 9 is set on every debug event and stays set until software writes the fault status register.
- R12: Read-back is masked. Watch control keeps only bits [3:0] and 8. Debug status keeps only bits 31 and [4:2]. Fault status keeps only bit 9. The breakpoint and data-address registers keep all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 32 | Instruction fetch address |
| sw_bkpt | input | 1 | Software breakpoint instruction executed |
| data_valid | input | 1 | Data access strobe |
| data_addr | input | 32 | Data access address |
| data_write | input | 1 | Access direction, 1 = write |
| dbg_event | output | 1 | Debug event pulse |
| dbg_moe | output | 3 | Recorded method-of-entry code |
| dbg_global_en | output | 1 | Global watchpoint enable |

## Verification
The assertions check on every cycle that no watchpoint hits while the global enable is off, and that watchpoint 1 stays silent in mask mode. They also check that a read-mode hit never occurs on a write, that an instruction-breakpoint hit is always recorded with code 1, that an event always leaves a nonzero code and the fault flag set, and that the code holds when nothing updates it. Whether the right addresses match is shown only by the bench's scenarios. The same holds for ignored low fetch bits, masked range compares, the mode codes, register read-back masking and the release of the pulse on the following cycle.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
   localparam int REG_W   = 32;
   localparam int RIDX_W  = 3;
   localparam int NUM_IBP = 2;
   localparam int NUM_WP  = 2;

   typedef enum logic [1:0] {
      WM_OFF   = 2'd0,
      WM_WRITE = 2'd1,
      WM_ANY   = 2'd2,
      WM_READ  = 2'd3
   } wmode_e;

   localparam logic [2:0] MOE_NONE  = 3'd0;
   localparam logic [2:0] MOE_HWBP  = 3'd1;
   localparam logic [2:0] MOE_WATCH = 3'd2;
   localparam logic [2:0] MOE_SWBP  = 3'd3;

   localparam logic [RIDX_W-1:0] RA_IBP0 = 3'd0;
   localparam logic [RIDX_W-1:0] RA_IBP1 = 3'd1;
   localparam logic [RIDX_W-1:0] RA_DAR0 = 3'd2;
   localparam logic [RIDX_W-1:0] RA_DAR1 = 3'd3;
   localparam logic [RIDX_W-1:0] RA_WCTL = 3'd4;
   localparam logic [RIDX_W-1:0] RA_DSTS = 3'd5;
   localparam logic [RIDX_W-1:0] RA_FSTS = 3'd6;

   localparam int GE_BIT    = 31;
   localparam int MOE_LO    = 2;
   localparam int MASK_BIT  = 8;
   localparam int FAULT_BIT = 9;

   function automatic logic dir_ok(input wmode_e m, input logic wr);
      case (m)
         WM_WRITE: dir_ok = wr;
         WM_READ:  dir_ok = ~wr;
         WM_ANY:   dir_ok = 1'b1;
         default:  dir_ok = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/dbgm_regs.sv
module dbgm_regs
   import dbgm_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [RIDX_W-1:0]               addr,
   input  logic [REG_W-1:0]                wdata,
   input  logic                            evt_set,
   input  logic [2:0]                      evt_moe,
   output logic [REG_W-1:0]                rdata,
   output logic [NUM_IBP-1:0][REG_W-1:0]   ibp,
   output logic [NUM_WP-1:0][ADDR_W-1:0]   dar,
   output wmode_e                          wmode [NUM_WP],
   output logic                            mask_mode,
   output logic                            global_en,
   output logic [2:0]                      moe,
   output logic                            fault_flag
);
   logic [NUM_IBP-1:0][REG_W-1:0] ibp_q;
   logic [NUM_WP-1:0][ADDR_W-1:0] dar_q;
   logic [2*NUM_WP-1:0]           wmode_q;
   logic                          mask_q;
   logic                          ge_q;
   logic [2:0]                    moe_q;
   logic                          fault_q;

   for (genvar i = 0; i < NUM_IBP; i++) begin : g_ibp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ibp_q[i] <= '0;
         else if (we && addr == RIDX_W'(RA_IBP0 + i))
            ibp_q[i] <= wdata;
      end
   end

   for (genvar i = 0; i < NUM_WP; i++) begin : g_dar
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dar_q[i] <= '0;
         else if (we && addr == RIDX_W'(RA_DAR0 + i))
            dar_q[i] <= wdata[ADDR_W-1:0];
      end
      assign wmode[i] = wmode_e'(wmode_q[2*i +: 2]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wmode_q <= '0;
         mask_q  <= 1'b0;
      end else if (we && addr == RA_WCTL) begin
         wmode_q <= wdata[2*NUM_WP-1:0];
         mask_q  <= wdata[MASK_BIT];
      end
   end

   // Event update takes precedence over a same-cycle software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ge_q    <= 1'b0;
         moe_q   <= MOE_NONE;
         fault_q <= 1'b0;
      end else begin
         if (we && addr == RA_DSTS) begin
            ge_q  <= wdata[GE_BIT];
            moe_q <= wdata[MOE_LO +: 3];
         end
         if (we && addr == RA_FSTS)
            fault_q <= wdata[FAULT_BIT];
         if (evt_set) begin
            moe_q   <= evt_moe;
            fault_q <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RA_IBP0: rdata = ibp_q[0];
         RA_IBP1: rdata = ibp_q[1];
         RA_DAR0: rdata = REG_W'(dar_q[0]);
         RA_DAR1: rdata = REG_W'(dar_q[1]);
         RA_WCTL: begin
            rdata[2*NUM_WP-1:0] = wmode_q;
            rdata[MASK_BIT]     = mask_q;
         end
         RA_DSTS: begin
            rdata[GE_BIT]       = ge_q;
            rdata[MOE_LO +: 3]  = moe_q;
         end
         RA_FSTS: rdata[FAULT_BIT] = fault_q;
         default: rdata = '0;
      endcase
   end

   assign ibp        = ibp_q;
   assign dar        = dar_q;
   assign mask_mode  = mask_q;
   assign global_en  = ge_q;
   assign moe        = moe_q;
   assign fault_flag = fault_q;

   // R11: an event always leaves the fault flag set on the next cycle
   p_fault_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set |=> fault_q);
endmodule

// File: rtl/dbgm_ibp_cmp.sv
module dbgm_ibp_cmp
   import dbgm_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic [REG_W-1:0]  bp_reg,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

   logic [ADDR_W-1:0] diff;

   assign diff = (fetch_addr ^ bp_reg[ADDR_W-1:0]) & WORD_MASK;
   assign hit  = fetch_valid & bp_reg[0] & (diff == '0);
endmodule

// File: rtl/dbgm_watch_cmp.sv
module dbgm_watch_cmp
   import dbgm_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  wmode_e                        wmode [NUM_WP],
   input  logic                          mask_mode,
   input  logic                          global_en,
   input  logic [NUM_WP-1:0][ADDR_W-1:0] dar,
   input  logic                          data_valid,
   input  logic [ADDR_W-1:0]             data_addr,
   input  logic                          data_write,
   output logic [NUM_WP-1:0]             hit
);
   logic [NUM_WP-1:0] addr_ok;
   logic              qual;

   assign qual = data_valid & global_en;

   for (genvar i = 0; i < NUM_WP; i++) begin : g_lane
      if (i == 0) begin : g_base
         logic [ADDR_W-1:0] ign;
         assign ign        = mask_mode ? dar[1] : '0;
         assign addr_ok[i] = ((data_addr ^ dar[0]) & ~ign) == '0;
      end else begin : g_plain
         assign addr_ok[i] = ~mask_mode & (data_addr == dar[i]);
      end
      assign hit[i] = qual & addr_ok[i] & dir_ok(wmode[i], data_write);

      // R4: a read-mode hit never comes from a write access
      p_read_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && wmode[i] == WM_READ) |-> !data_write);
   end

   // R5: global enable off forbids every watchpoint hit
   p_ge_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !global_en |-> (hit == '0));

   // R6: in mask mode watchpoint 1 is unused
   p_mask_lane1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_mode |-> !hit[1]);
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
   import dbgm_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [RIDX_W-1:0]    reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic                 fetch_valid,
   input  logic [ADDR_W-1:0]    fetch_addr,
   input  logic                 sw_bkpt,
   input  logic                 data_valid,
   input  logic [ADDR_W-1:0]    data_addr,
   input  logic                 data_write,
   output logic                 dbg_event,
   output logic [2:0]           dbg_moe,
   output logic                 dbg_global_en
);
   if (ADDR_W < 8 || ADDR_W > REG_W) begin : g_bad_addr_w
      $error("dbg_match_unit: ADDR_W must lie in 8..32");
   end

   logic [NUM_IBP-1:0][REG_W-1:0]  ibp;
   logic [NUM_WP-1:0][ADDR_W-1:0]  dar;
   wmode_e                         wmode [NUM_WP];
   logic                           mask_mode;
   logic                           global_en;
   logic                           fault_flag;
   logic [NUM_IBP-1:0]             ibp_hit;
   logic [NUM_WP-1:0]              wp_hit;
   logic                           any_hit;
   logic [2:0]                     moe_next;
   logic                           evt_q;

   dbgm_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (reg_we),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .evt_set    (any_hit),
      .evt_moe    (moe_next),
      .rdata      (reg_rdata),
      .ibp        (ibp),
      .dar        (dar),
      .wmode      (wmode),
      .mask_mode  (mask_mode),
      .global_en  (global_en),
      .moe        (dbg_moe),
      .fault_flag (fault_flag)
   );

   for (genvar i = 0; i < NUM_IBP; i++) begin : g_bp
      dbgm_ibp_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .bp_reg      (ibp[i]),
         .fetch_valid (fetch_valid),
         .fetch_addr  (fetch_addr),
         .hit         (ibp_hit[i])
      );
   end

   dbgm_watch_cmp #(.ADDR_W(ADDR_W)) u_watch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wmode      (wmode),
      .mask_mode  (mask_mode),
      .global_en  (global_en),
      .dar        (dar),
      .data_valid (data_valid),
      .data_addr  (data_addr),
      .data_write (data_write),
      .hit        (wp_hit)
   );

   // Cause priority: instruction breakpoint, software breakpoint, watchpoint
   always_comb begin
      if (|ibp_hit)     moe_next = MOE_HWBP;
      else if (sw_bkpt) moe_next = MOE_SWBP;
      else if (|wp_hit) moe_next = MOE_WATCH;
      else              moe_next = MOE_NONE;
   end

   assign any_hit = (|ibp_hit) | sw_bkpt | (|wp_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= any_hit;
   end

   assign dbg_event     = evt_q;
   assign dbg_global_en = global_en;

   // R9: an instruction breakpoint hit is always recorded as code 1
   p_bp_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|ibp_hit) |=> (dbg_moe == MOE_HWBP));

   // R10: an event pulse always carries a recorded cause
   p_event_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_event |-> (dbg_moe != MOE_NONE) && fault_flag);

   // R10: the code holds without an event or a status write
   p_moe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_hit && !(reg_we && reg_addr == RA_DSTS)) |=> $stable(dbg_moe));
endmodule

// File: tb/sim_dbg_match_unit.sv
module sim_dbg_match_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        fv;
      logic [31:0] fa;
      logic        sw;
      logic        dv;
      logic [31:0] da;
      logic        dw;
      logic        ev;
      logic [2:0]  moe;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 32'h1000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 3'd1},
      '{1'b1, 32'h1003, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 3'd1},
      '{1'b1, 32'h2004, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 3'd1},
      '{1'b1, 32'h1004, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 3'd0},
      '{1'b0, 32'h1000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 3'd0},
      '{1'b0, 32'h0,    1'b0, 1'b1, 32'h3000, 1'b1, 1'b1, 3'd2},
      '{1'b0, 32'h0,    1'b0, 1'b1, 32'h3000, 1'b0, 1'b0, 3'd0},
      '{1'b0, 32'h0,    1'b0, 1'b1, 32'h3100, 1'b0, 1'b1, 3'd2},
      '{1'b0, 32'h0,    1'b0, 1'b1, 32'h3100, 1'b1, 1'b0, 3'd0},
      '{1'b0, 32'h0,    1'b1, 1'b0, 32'h0,    1'b0, 1'b1, 3'd3},
      '{1'b1, 32'h1000, 1'b1, 1'b1, 32'h3000, 1'b1, 1'b1, 3'd1},
      '{1'b0, 32'h0,    1'b1, 1'b1, 32'h3000, 1'b1, 1'b1, 3'd3},
      '{1'b0, 32'h0,    1'b0, 1'b1, 32'h3001, 1'b1, 1'b0, 3'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        sw_bkpt = 1'b0;
   logic        data_valid = 1'b0;
   logic [31:0] data_addr = '0;
   logic        data_write = 1'b0;
   logic        dbg_event;
   logic [2:0]  dbg_moe;
   logic        dbg_global_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_match_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .sw_bkpt(sw_bkpt),
      .data_valid(data_valid), .data_addr(data_addr), .data_write(data_write),
      .dbg_event(dbg_event), .dbg_moe(dbg_moe), .dbg_global_en(dbg_global_en)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic idle_inputs();
      fetch_valid = 1'b0; sw_bkpt = 1'b0; data_valid = 1'b0; data_write = 1'b0;
   endtask

   // Drive one cycle of stimulus, then sample the registered result
   task automatic pulse(input logic fv, input logic [31:0] fa, input logic sw,
                        input logic dv, input logic [31:0] da, input logic dw);
      @(negedge clk);
      fetch_valid = fv; fetch_addr = fa; sw_bkpt = sw;
      data_valid = dv; data_addr = da; data_write = dw;
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin
      #(CLK_PERIOD*20000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 event", {31'b0, dbg_event}, 32'h0);
      chk("R1 moe", {29'b0, dbg_moe}, 32'h0);
      chk("R1 ge", {31'b0, dbg_global_en}, 32'h0);
      rst_n = 1'b1;
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), r);
         chk($sformatf("R1 reg%0d", a), r, 32'h0);
      end

      // R12: read-back masks
      wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, r); chk("R12 wctl mask", r, 32'h0000_010F);
      wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, r); chk("R12 dsts mask", r, 32'h8000_001C);
      chk("R5 ge pin", {31'b0, dbg_global_en}, 32'h1);
      wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, r); chk("R12 fsts mask", r, 32'h0000_0200);
      wr(3'd3, 32'hA5A5_5A5A); rd(3'd3, r); chk("R12 dar1 full", r, 32'hA5A5_5A5A);

      // Base configuration for the vector table
      wr(3'd0, 32'h0000_1001);
      wr(3'd1, 32'h0000_2005);
      wr(3'd2, 32'h0000_3000);
      wr(3'd3, 32'h0000_3100);
      wr(3'd4, 32'h0000_000D);   // wp0 write, wp1 read
      wr(3'd6, 32'h0);

      // R2 R3 R4 R7 R8 R9: vector table
      for (int i = 0; i < NV; i++) begin
         wr(3'd5, 32'h8000_0000);
         pulse(VECS[i].fv, VECS[i].fa, VECS[i].sw, VECS[i].dv, VECS[i].da, VECS[i].dw);
         chk($sformatf("R2/R4/R7/R8/R9 vec%0d event", i), {31'b0, dbg_event}, {31'b0, VECS[i].ev});
         chk($sformatf("R2/R4/R7/R8/R9 vec%0d moe", i), {29'b0, dbg_moe}, {29'b0, VECS[i].moe});
      end

      // R10: pulse drops next cycle, code holds
      wr(3'd5, 32'h8000_0000);
      pulse(1'b0, 32'h0, 1'b0, 1'b1, 32'h3000, 1'b1);
      chk("R10 pulse high", {31'b0, dbg_event}, 32'h1);
      @(negedge clk);
      chk("R10 pulse low", {31'b0, dbg_event}, 32'h0);
      chk("R10 moe held", {29'b0, dbg_moe}, 32'h2);
      rd(3'd5, r); chk("R10 dsts moe field", r, 32'h8000_0008);

      // R11: fault flag sticky then cleared by software
      rd(3'd6, r); chk("R11 fault set", r, 32'h0000_0200);
      @(negedge clk);
      rd(3'd6, r); chk("R11 fault sticky", r, 32'h0000_0200);
      wr(3'd6, 32'h0); rd(3'd6, r); chk("R11 fault cleared", r, 32'h0);

      // R5: global enable off blocks watchpoints only
      wr(3'd5, 32'h0);
      pulse(1'b0, 32'h0, 1'b0, 1'b1, 32'h3000, 1'b1);
      chk("R5 watch gated", {31'b0, dbg_event}, 32'h0);
      pulse(1'b1, 32'h1000, 1'b0, 1'b0, 32'h0, 1'b0);
      chk("R5 bp ungated", {29'b0, dbg_moe}, 32'h1);
      pulse(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0);
      chk("R5 swbp ungated", {29'b0, dbg_moe}, 32'h3);

      // R4: access mode matches both directions
      wr(3'd4, 32'h0000_0002);
      wr(3'd5, 32'h8000_0000);
      pulse(1'b0, 32'h0, 1'b0, 1'b1, 32'h3000, 1'b0);
      chk("R4 any read", {31'b0, dbg_event}, 32'h1);
      pulse(1'b0, 32'h0, 1'b0, 1'b1, 32'h3000, 1'b1);
      chk("R4 any write", {31'b0, dbg_event}, 32'h1);
      pulse(1'b0, 32'h0, 1'b0, 1'b1, 32'h3100, 1'b0);
      chk("R4 wp1 off", {31'b0, dbg_event}, 32'h0);

      // R6: mask mode range watch, wp1 unused
      wr(3'd2, 32'h0000_4000);
      wr(3'd3, 32'h0000_00FF);
      wr(3'd4, 32'h0000_010E);
      pulse(1'b0, 32'h0, 1'b0, 1'b1, 32'h0000_40AB, 1'b1);
      chk("R6 masked hit", {31'b0, dbg_event}, 32'h1);
      pulse(1'b0, 32'h0, 1'b0, 1'b1, 32'h0000_4100, 1'b1);
      chk("R6 outside range", {31'b0, dbg_event}, 32'h0);
      pulse(1'b0, 32'h0, 1'b0, 1'b1, 32'h0000_00FF, 1'b0);
      chk("R6 wp1 unused", {31'b0, dbg_event}, 32'h0);

      // R3: disabled breakpoints
      wr(3'd0, 32'h0);
      pulse(1'b1, 32'h1000, 1'b0, 1'b0, 32'h0, 1'b0);
      chk("R3 written zero", {31'b0, dbg_event}, 32'h0);
      wr(3'd0, 32'h0000_1000);
      pulse(1'b1, 32'h1000, 1'b0, 1'b0, 32'h0, 1'b0);
      chk("R3 enable clear", {31'b0, dbg_event}, 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule